// File: doc/BRIEF.md
# Sparse-Operand Quartic Extension Field Multiplier

This block multiplies an element C of GF(2^(4m)) by a sparse element A and returns the product in a single subfield multiplication round. C has four GF(2^m) coordinates c0, c1, c2, c3 on the basis {1, s, t, st}, where s^2 + s + 1 = 0 and t^2 + t + s = 0. A is w + z·s + e·t: two GF(2^m) elements and one bit. The t-bit e is 1 while a pairing loop accumulates line values. It is 0 when the same unit serves as a general multiplier by a GF(2^(2m)) element.

The top forms exactly six GF(2^m) products at once: c0·w, c1·z, c2·w, c3·z, (c0+c1)(w+z) and (c2+c3)(w+z). It uses six digit-serial multipliers that scan the first factor most-significant digit first. Multipliers with the same second factor (w, z or w+z) take their pre-reduced shifts x^i·b mod f from one shared array. The field degree m, the low terms of the reduction polynomial and the digit width D are parameters. The defaults are m = 239, f = x^239 + x^36 + 1 and D = 16.

A one-cycle start pulse loads all operands. After the run, four registered coordinates appear together with a one-cycle done pulse.

Top module: `gf4m_sparse_mul`

## Requirements
- R1: On completion, c0_o = c0·w + c1·z + e·c3 and c2_o = c2·w + c3·z + e·(c0 + c2). Products are in GF(2^m), addition is bitwise XOR, and bit k of each vector is the coefficient of x^k.
- R2: On completion, c1_o = (c0+c1)(w+z) + c0·w + e·(c2+c3) and c3_o = (c2+c3)(w+z) + c2·w + e·(c1+c3).
- R3: With e = 0, every output coordinate has no e-term: only the subfield product sums of R1 and R2 remain.
- R4: Products are reduced modulo f = x^M + RED_LOW. With the defaults this is x^239 + x^36 + 1, so every output is below degree 239, including all-ones operands and operands x^238.
- R5: done_o rises NDIG+1 rising clock edges after the edge that accepts start_i, where NDIG = ceil(M/D) (15 by default).
- R6: done_o is high for exactly one cycle. The output coordinates change only on the edge that raises done_o and hold their values otherwise.
- R7: Operands are captured on the accepting edge only. A start_i pulse, or an input change, while a product is in progress has no effect on that product or on its timing.
- R8: After reset, done_o is 0 and all four output coordinates are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Pulse to load operands and begin a product |
| c0_i | input | M | Coordinate of C on 1 |
| c1_i | input | M | Coordinate of C on s |
| c2_i | input | M | Coordinate of C on t |
| c3_i | input | M | Coordinate of C on st |
| w_i | input | M | Coordinate of A on 1 |
| z_i | input | M | Coordinate of A on s |
| e_i | input | 1 | Coordinate bit of A on t |
| c0_o | output | M | Product coordinate on 1 |
| c1_o | output | M | Product coordinate on s |
| c2_o | output | M | Product coordinate on t |
| c3_o | output | M | Product coordinate on st |
| done_o | output | 1 | One-cycle pulse: outputs updated |

## Verification
Each port-visible symptom traces back to one part of the design:

- A fault in one of the six digit accumulators, or in the digit select, shows up only as wrong coordinates in the cycle done_o rises.
- A fault in a shared shift array corrupts every coordinate that uses that second factor.
- A slip in the digit counter or the state sequence moves done_o away from edge NDIG+1, so it appears in the cycle the pulse is due.
- A leak through the load enable appears after an ignored mid-run start as coordinates that belong to the wrong operands.

// File: rtl/gf4m_pkg.sv
package gf4m_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } gf4m_state_e;
endpackage

// File: rtl/gf4m_shift_array.sv
module gf4m_shift_array #(
  parameter int M = 239,
  parameter int D = 16,
  parameter logic [M-1:0] RED_LOW = M'(64'h0000_0010_0000_0001)
) (
  input  logic [M-1:0]   b_i,
  output logic [D*M-1:0] sh_o
);
  always_comb begin : build
    logic [M-1:0] t;
    t = b_i;
    for (int i = 0; i < D; i++) begin
      sh_o[i*M +: M] = t;
      t = {t[M-2:0], 1'b0} ^ (t[M-1] ? RED_LOW : '0);
    end
  end
endmodule

// File: rtl/gf4m_digit_mac.sv
module gf4m_digit_mac #(
  parameter int M = 239,
  parameter int D = 16,
  parameter logic [M-1:0] RED_LOW = M'(64'h0000_0010_0000_0001)
) (
  input  logic [M-1:0]   acc_i,
  input  logic [D-1:0]   dig_i,
  input  logic [D*M-1:0] bx_i,
  output logic [M-1:0]   acc_o
);
  always_comb begin : step
    logic [M-1:0] t;
    t = acc_i;
    for (int i = 0; i < D; i++) begin
      t = {t[M-2:0], 1'b0} ^ (t[M-1] ? RED_LOW : '0);
    end
    for (int i = 0; i < D; i++) begin
      if (dig_i[i]) t = t ^ bx_i[i*M +: M];
    end
    acc_o = t;
  end
endmodule

// File: rtl/gf4m_sparse_mul.sv
module gf4m_sparse_mul
  import gf4m_pkg::*;
#(
  parameter int M = 239,
  parameter int D = 16,
  parameter logic [M-1:0] RED_LOW = M'(64'h0000_0010_0000_0001)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [M-1:0] c0_i,
  input  logic [M-1:0] c1_i,
  input  logic [M-1:0] c2_i,
  input  logic [M-1:0] c3_i,
  input  logic [M-1:0] w_i,
  input  logic [M-1:0] z_i,
  input  logic         e_i,
  output logic [M-1:0] c0_o,
  output logic [M-1:0] c1_o,
  output logic [M-1:0] c2_o,
  output logic [M-1:0] c3_o,
  output logic         done_o
);
  localparam int NDIG = (M + D - 1) / D;
  localparam int NP   = NDIG * D;
  localparam int CW   = (NDIG > 1) ? $clog2(NDIG) : 1;
  localparam int NPROD = 6;

  // reset: asserted asynchronously, released after two clean edges
  logic rs_q1, rs_q2, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_core_n = rs_q2;

  gf4m_state_e     st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [M-1:0]    cr_q [4];
  logic [M-1:0]    w_q, z_q;
  logic            e_q;
  logic [M-1:0]    acc_q  [NPROD];
  logic [M-1:0]    acc_d  [NPROD];
  logic [M-1:0]    acc_nx [NPROD];
  logic [M-1:0]    out_q  [4];
  logic [M-1:0]    out_d  [4];
  logic            done_q, done_d;
  logic            ld_en, run_en, fin_en, busy;

  assign ld_en  = (st_q == ST_IDLE) && start_i;
  assign run_en = (st_q == ST_RUN);
  assign fin_en = (st_q == ST_FIN);
  assign busy   = (st_q != ST_IDLE);

  // second factors, each feeding one shared shift array
  logic [M-1:0]   bsrc [3];
  logic [D*M-1:0] bx   [3];
  assign bsrc[0] = w_q;
  assign bsrc[1] = z_q;
  assign bsrc[2] = w_q ^ z_q;

  for (genvar j = 0; j < 3; j++) begin : g_shared
    gf4m_shift_array #(.M(M), .D(D), .RED_LOW(RED_LOW)) u_sh (
      .b_i (bsrc[j]),
      .sh_o(bx[j])
    );
  end

  // first factors, scanned digit by digit from the top
  logic [M-1:0] opa [NPROD];
  assign opa[0] = cr_q[0];
  assign opa[1] = cr_q[1];
  assign opa[2] = cr_q[2];
  assign opa[3] = cr_q[3];
  assign opa[4] = cr_q[0] ^ cr_q[1];
  assign opa[5] = cr_q[2] ^ cr_q[3];

  for (genvar g = 0; g < NPROD; g++) begin : g_prod
    localparam int BI = (g >= 4) ? 2 : (g % 2);
    logic [NP-1:0] pad;
    logic [D-1:0]  dig;
    always_comb begin
      pad = '0;
      pad[M-1:0] = opa[g];
    end
    assign dig = pad[cnt_q*D +: D];
    gf4m_digit_mac #(.M(M), .D(D), .RED_LOW(RED_LOW)) u_mac (
      .acc_i(acc_q[g]),
      .dig_i(dig),
      .bx_i (bx[BI]),
      .acc_o(acc_nx[g])
    );
  end

  // next state
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        st_d  = ST_RUN;
        cnt_d = CW'(NDIG - 1);
      end
      ST_RUN: begin
        if (cnt_q == '0) st_d = ST_FIN;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    for (int g = 0; g < NPROD; g++) begin
      if (ld_en)       acc_d[g] = '0;
      else if (run_en) acc_d[g] = acc_nx[g];
      else             acc_d[g] = acc_q[g];
    end
  end

  // combine the six products with the t-bit terms
  always_comb begin
    out_d[0] = acc_q[0] ^ acc_q[1] ^ (e_q ? cr_q[3] : '0);
    out_d[1] = acc_q[4] ^ acc_q[0] ^ (e_q ? (cr_q[2] ^ cr_q[3]) : '0);
    out_d[2] = acc_q[2] ^ acc_q[3] ^ (e_q ? (cr_q[0] ^ cr_q[2]) : '0);
    out_d[3] = acc_q[5] ^ acc_q[2] ^ (e_q ? (cr_q[1] ^ cr_q[3]) : '0);
    done_d   = fin_en;
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      for (int k = 0; k < 4; k++) cr_q[k] <= '0;
      w_q <= '0;
      z_q <= '0;
      e_q <= 1'b0;
    end else if (ld_en) begin
      cr_q[0] <= c0_i;
      cr_q[1] <= c1_i;
      cr_q[2] <= c2_i;
      cr_q[3] <= c3_i;
      w_q     <= w_i;
      z_q     <= z_i;
      e_q     <= e_i;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      for (int g = 0; g < NPROD; g++) acc_q[g] <= '0;
    end else if (ld_en || run_en) begin
      for (int g = 0; g < NPROD; g++) acc_q[g] <= acc_d[g];
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      for (int k = 0; k < 4; k++) out_q[k] <= '0;
    end else if (fin_en) begin
      for (int k = 0; k < 4; k++) out_q[k] <= out_d[k];
    end
  end

  assign c0_o   = out_q[0];
  assign c1_o   = out_q[1];
  assign c2_o   = out_q[2];
  assign c3_o   = out_q[3];
  assign done_o = done_q;
endmodule

// File: rtl/gf4m_sparse_mul_chk.sv
module gf4m_sparse_mul_chk #(
  parameter int M = 239,
  parameter int D = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         busy,
  input logic         done_o,
  input logic [M-1:0] c0_o,
  input logic [M-1:0] c1_o,
  input logic [M-1:0] c2_o,
  input logic [M-1:0] c3_o
);
  localparam int LAT  = (M + D - 1) / D + 1;
  localparam int IDLE_MARK = LAT + 100;

  int cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cyc <= IDLE_MARK;
    else if (start_i && !busy)   cyc <= 0;
    else if (cyc < IDLE_MARK)    cyc <= cyc + 1;
  end

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable({c0_o, c1_o, c2_o, c3_o}));

  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cyc == LAT));

  p_start_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_i));
endmodule

bind gf4m_sparse_mul gf4m_sparse_mul_chk #(.M(M), .D(D)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start_i(start_i),
  .busy   (busy),
  .done_o (done_o),
  .c0_o   (c0_o),
  .c1_o   (c1_o),
  .c2_o   (c2_o),
  .c3_o   (c3_o)
);

// File: tb/sim_gf4m_sparse_mul.sv
module sim_gf4m_sparse_mul;
  localparam int M = 239;
  localparam int D = 16;
  localparam int NDIG = (M + D - 1) / D;
  localparam logic [M-1:0] RED = M'(64'h0000_0010_0000_0001);
  localparam int NVEC = 12;
  // entry = {pattern kind[3:0], e}
  localparam logic [4:0] VEC [NVEC] = '{
    {4'd0, 1'b1}, {4'd0, 1'b0}, {4'd1, 1'b1}, {4'd1, 1'b0},
    {4'd2, 1'b1}, {4'd2, 1'b0}, {4'd3, 1'b1}, {4'd3, 1'b0},
    {4'd4, 1'b1}, {4'd4, 1'b0}, {4'd5, 1'b1}, {4'd5, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [M-1:0] c0 = '0, c1 = '0, c2 = '0, c3 = '0, w = '0, z = '0;
  logic e = 1'b0;
  logic [M-1:0] q0, q1, q2, q3;
  logic done;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  gf4m_sparse_mul #(.M(M), .D(D), .RED_LOW(RED)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .c0_i(c0), .c1_i(c1), .c2_i(c2), .c3_i(c3),
    .w_i(w), .z_i(z), .e_i(e),
    .c0_o(q0), .c1_o(q1), .c2_o(q2), .c3_o(q3), .done_o(done)
  );

  function automatic logic [M-1:0] xt(input logic [M-1:0] v);
    return {v[M-2:0], 1'b0} ^ (v[M-1] ? RED : '0);
  endfunction

  function automatic logic [M-1:0] gmul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      r = xt(r);
      if (a[i]) r = r ^ b;
    end
    return r;
  endfunction

  function automatic logic [M-1:0] rnd();
    logic [255:0] t;
    for (int k = 0; k < 8; k++) t[k*32 +: 32] = $urandom();
    return t[M-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [M-1:0] act, input logic [M-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  // drive one product; optionally poke start and inputs while busy
  task automatic run_op(input logic [M-1:0] a0, a1, a2, a3, bw, bz,
                        input logic be, input int poke_at, output int lat);
    @(negedge clk);
    c0 = a0; c1 = a1; c2 = a2; c3 = a3; w = bw; z = bz; e = be; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 1000) begin
      if (lat == poke_at) begin
        start = 1'b1; c0 = ~a0; c2 = ~a2; w = ~bw; e = ~be;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    if (lat >= 1000) chk(1'b0, "R5", "watchdog on done", M'(lat), M'(NDIG + 2));
  endtask

  task automatic expect_out(input logic [M-1:0] a0, a1, a2, a3, bw, bz,
                            input logic be, input string tag0, input string tag1);
    logic [M-1:0] p0, p1, p2, p3, p4, p5, x0, x1, x2, x3;
    p0 = gmul(a0, bw); p1 = gmul(a1, bz); p2 = gmul(a2, bw); p3 = gmul(a3, bz);
    p4 = gmul(a0 ^ a1, bw ^ bz); p5 = gmul(a2 ^ a3, bw ^ bz);
    x0 = p0 ^ p1 ^ (be ? a3 : '0);
    x1 = p4 ^ p0 ^ (be ? (a2 ^ a3) : '0);
    x2 = p2 ^ p3 ^ (be ? (a0 ^ a2) : '0);
    x3 = p5 ^ p2 ^ (be ? (a1 ^ a3) : '0);
    chk(q0 == x0, tag0, "c0", q0, x0);
    chk(q1 == x1, tag1, "c1", q1, x1);
    chk(q2 == x2, tag0, "c2", q2, x2);
    chk(q3 == x3, tag1, "c3", q3, x3);
  endtask

  initial begin
    #(200000 * 20);
    chk(1'b0, "R5", "global watchdog", '0, '1);
    finish_run();
  end

  initial begin
    int lat;
    logic [M-1:0] a0, a1, a2, a3, bw, bz, h0;
    logic be;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8: reset state
    chk(done == 1'b0, "R8", "done after reset", M'(done), '0);
    chk(q0 == '0 && q1 == '0 && q2 == '0 && q3 == '0, "R8", "outputs after reset", q0 | q1 | q2 | q3, '0);

    for (int v = 0; v < NVEC; v++) begin
      be = VEC[v][0];
      unique case (VEC[v][4:1])
        4'd0: begin a0 = rnd(); a1 = rnd(); a2 = rnd(); a3 = rnd(); bw = rnd(); bz = rnd(); end
        4'd1: begin a0 = '0; a1 = '0; a2 = '0; a3 = '0; bw = rnd(); bz = rnd(); end
        4'd2: begin a0 = '1; a1 = '1; a2 = '1; a3 = '1; bw = '1; bz = '1; end
        4'd3: begin a0 = rnd(); a1 = rnd(); a2 = rnd(); a3 = rnd(); bw = '0; bz = '0; end
        4'd4: begin a0 = M'(1); a1 = '0; a2 = '0; a3 = '0; bw = rnd(); bz = rnd(); end
        default: begin
          a0 = {1'b1, {(M-1){1'b0}}}; a1 = a0; a2 = a0; a3 = a0; bw = a0; bz = a0 >> 1;
        end
      endcase
      run_op(a0, a1, a2, a3, bw, bz, be, 0, lat);
      chk(lat == NDIG + 2, "R5", "done latency", M'(lat), M'(NDIG + 2));
      if (VEC[v][4:1] == 4'd2 || VEC[v][4:1] == 4'd5)
        expect_out(a0, a1, a2, a3, bw, bz, be, "R4", "R4");
      else if (!be)
        expect_out(a0, a1, a2, a3, bw, bz, be, "R1/R3", "R2/R3");
      else
        expect_out(a0, a1, a2, a3, bw, bz, be, "R1", "R2");
    end

    // R6: single-cycle pulse and held outputs
    h0 = q0;
    @(negedge clk);
    chk(done == 1'b0, "R6", "done width", M'(done), '0);
    repeat (5) @(negedge clk);
    chk(q0 == h0, "R6", "output hold", q0, h0);

    // R7: start and input changes while busy are ignored
    a0 = rnd(); a1 = rnd(); a2 = rnd(); a3 = rnd(); bw = rnd(); bz = rnd();
    run_op(a0, a1, a2, a3, bw, bz, 1'b1, 3, lat);
    chk(lat == NDIG + 2, "R7", "latency with mid-run start", M'(lat), M'(NDIG + 2));
    expect_out(a0, a1, a2, a3, bw, bz, 1'b1, "R7", "R7");
    @(negedge clk);
    chk(done == 1'b0, "R7", "no second run", M'(done), '0);

    finish_run();
  end
endmodule